// File: doc/BRIEF.md
# Fault and Status Interrupt Controller

This block gathers a vector of fault and status event inputs and presents them to software as three register views: live flags that mirror the current event state, sticky latched flags that record every event seen, and mask bits that decide which latched flags may raise the interrupt request pin. Live flags exist only for the sources that are configured to have one. They are valid only while the device is in active mode and read as zero at all other times. Latched flags survive shutdown, so software can inspect them after a fault has stopped the device.

The interrupt pin can be driven open-drain or push-pull, with either polarity. A two-bit mode field picks what drives it: the latched flags, the live flags, a fixed-length pulse for each newly latched flag, or nothing. A single self-clearing command bit clears every latched flag at once. Software reaches all of this through a small address/data register bus with combinational read data.

Top module: `irq_ctl`

## Requirements
- R1: After reset, live and latched flags read 0, the mask reads the MASK_INIT parameter and the config register reads 0 (latched-level mode, active low, open-drain), so the pin is released (irq_oe_o = 0, irq_o = 0).
- R2: Register address 0 returns the live flags. One clock after an edge that samples active_i = 1, each live bit equals its event input if the HAS_LIVE parameter gives it a live bit and reads 0 if not. One clock after an edge that samples active_i = 0, all live bits read 0.
- R3: Register address 1 returns the latched flags. An event bit sampled high sets its latched bit at that edge, whatever the value of active_i. The bit stays set after the event drops and through shutdown, until a clear is issued.
- R4: Writing address 3 with bit 3 set clears every latched flag at that edge, and bit 3 always reads back 0. If an event is high in the same cycle as the clear, that event's latched bit is set.
- R5: Address 2 is the read/write mask register, where 1 masks a source. In mode 00 the request is asserted while any latched bit whose mask bit is 0 is set.
- R6: In mode 01 the request is asserted while any live bit whose mask bit is 0 is set.
- R7: In mode 10, an event on an unmasked source whose latched bit was clear starts a request pulse exactly PULSE_CYCLES clocks long, beginning right after that edge. Events on sources that are already latched, or on masked sources, start no pulse.
- R8: In mode 11 the request never asserts, even when unmasked latched flags are set.
- R9: Config bit 0 selects polarity. With 0, the asserted pin level is low. With 1, the asserted pin level is high.
- R10: Config bit 4 selects the drive style. With 0 (open-drain), irq_o is always 0 and irq_oe_o is 1 exactly when the pin level is low. With 1 (push-pull), irq_oe_o is 1 and irq_o is the pin level. The mode field is config bits 2:1.
- R11: Writes to addresses 0 and 1 have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_i | input | 1 | Device is in active mode |
| evt_i | input | NUM_SRC | Event inputs, one per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 live, 1 latched, 2 mask, 3 config) |
| bus_wdata_i | input | NUM_SRC | Register write data |
| bus_rdata_o | output | NUM_SRC | Register read data for bus_addr_i |
| irq_o | output | 1 | Pin drive value |
| irq_oe_o | output | 1 | Pin output enable |

## Verification
The bench builds the block with eight sources. Sources 0 to 3 have live bits and are masked at reset, like warning levels. Sources 4 to 7 are latch-only and unmasked at reset, like shutdown errors. This split puts the missing live bits, the per-bit mask defaults and the sticky shutdown flags all within reach of a few vectors. PULSE_CYCLES is shrunk to 5, so the pulse mode's exact length and its refusal to retrigger on an already-latched or masked source can be counted cycle by cycle.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    typedef enum logic [1:0] {
        REG_LIVE  = 2'd0,
        REG_LATCH = 2'd1,
        REG_MASK  = 2'd2,
        REG_CFG   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PIN_LATCHED = 2'b00,
        PIN_LIVE    = 2'b01,
        PIN_PULSE   = 2'b10,
        PIN_OFF     = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic      push_pull;
        logic      clr;
        pin_mode_e mode;
        logic      pol;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic logic pin_level(input logic req, input logic pol);
        return pol ? req : !req;
    endfunction

endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
    parameter int                 NUM_SRC   = 8,
    parameter logic [NUM_SRC-1:0] HAS_LIVE  = 8'h0F,
    parameter logic [NUM_SRC-1:0] MASK_INIT = 8'h0F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active_i,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    output logic [NUM_SRC-1:0] live_o,
    output logic [NUM_SRC-1:0] lat_o,
    output logic [NUM_SRC-1:0] mask_o
);
    logic [NUM_SRC-1:0] lat_q;
    logic [NUM_SRC-1:0] mask_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (HAS_LIVE[i]) begin : g_live
            logic live_q;
            always_ff @(posedge clk) begin
                if (rst) live_q <= 1'b0;
                else     live_q <= active_i & evt_i[i];
            end
            assign live_o[i] = live_q;
        end else begin : g_nolive
            assign live_o[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q  <= '0;
            mask_q <= MASK_INIT;
        end else begin
            lat_q <= (clr_i ? '0 : lat_q) | evt_i;
            if (mask_we_i) mask_q <= mask_wdata_i;
        end
    end

    assign lat_o  = lat_q;
    assign mask_o = mask_q;

    // R3: latched bits never drop without a clear
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((lat_q & $past(lat_q)) == $past(lat_q)));
    // R3: an event always sets its latched bit
    a_r3_set: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((lat_q & $past(evt_i)) == $past(evt_i)));
    // R4: after a clear only same-cycle events remain
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (lat_q == $past(evt_i)));
    // R2: outside active mode live flags go to zero
    a_r2_live_off: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (live_o == '0));
endmodule

// File: rtl/irq_pulse.sv
module irq_pulse #(
    parameter int CYCLES = 49152
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R7: a load always restarts the full pulse length
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == LOAD_VAL));
    // R7: without a load the count only falls
    a_r7_falls: assert property (@(posedge clk) disable iff (rst)
        (!load_i && busy_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/irq_pin.sv
module irq_pin (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic pol_i,
    input  logic push_pull_i,
    output logic irq_o,
    output logic irq_oe_o
);
    import irq_ctl_pkg::*;

    logic level;

    always_comb begin
        level = pin_level(req_i, pol_i);
        if (push_pull_i) begin
            irq_oe_o = 1'b1;
            irq_o    = level;
        end else begin
            irq_oe_o = !level;
            irq_o    = 1'b0;
        end
    end

    // R10: open-drain never drives high
    a_r10_od_low: assert property (@(posedge clk) disable iff (rst)
        !push_pull_i |-> !irq_o);
    // R9: active-low request with open-drain pulls the pin
    a_r9_active_low: assert property (@(posedge clk) disable iff (rst)
        (req_i && !pol_i && !push_pull_i) |-> irq_oe_o);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
    parameter int                 NUM_SRC      = 8,
    parameter logic [NUM_SRC-1:0] HAS_LIVE     = 8'h0F,
    parameter logic [NUM_SRC-1:0] MASK_INIT    = 8'h0F,
    parameter int                 PULSE_CYCLES = 49152
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active_i,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               bus_wr_i,
    input  logic [1:0]         bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               irq_o,
    output logic               irq_oe_o
);
    import irq_ctl_pkg::*;

    cfg_t               cfg_q;
    cfg_t               cfg_wr;
    reg_addr_e          addr;
    logic               cfg_we, mask_we, clr;
    logic [NUM_SRC-1:0] live, lat, mask, fresh;
    logic               pulse_load, pulse_busy, req;

    assign addr    = reg_addr_e'(bus_addr_i);
    assign cfg_wr  = cfg_t'(bus_wdata_i[CFG_W-1:0]);
    assign cfg_we  = bus_wr_i && (addr == REG_CFG);
    assign mask_we = bus_wr_i && (addr == REG_MASK);
    assign clr     = cfg_we && cfg_wr.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q     <= cfg_wr;
            cfg_q.clr <= 1'b0;
        end
    end

    irq_flags #(
        .NUM_SRC  (NUM_SRC),
        .HAS_LIVE (HAS_LIVE),
        .MASK_INIT(MASK_INIT)
    ) u_flags (
        .clk         (clk),
        .rst         (rst),
        .active_i    (active_i),
        .evt_i       (evt_i),
        .clr_i       (clr),
        .mask_we_i   (mask_we),
        .mask_wdata_i(bus_wdata_i),
        .live_o      (live),
        .lat_o       (lat),
        .mask_o      (mask)
    );

    assign fresh      = evt_i & ~lat & ~mask;
    assign pulse_load = (cfg_q.mode == PIN_PULSE) && (|fresh);

    irq_pulse #(.CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .load_i(pulse_load),
        .busy_o(pulse_busy)
    );

    always_comb begin
        unique case (cfg_q.mode)
            PIN_LATCHED: req = |(lat & ~mask);
            PIN_LIVE:    req = |(live & ~mask);
            PIN_PULSE:   req = pulse_busy;
            default:     req = 1'b0;
        endcase
    end

    irq_pin u_pin (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .pol_i      (cfg_q.pol),
        .push_pull_i(cfg_q.push_pull),
        .irq_o      (irq_o),
        .irq_oe_o   (irq_oe_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (addr)
            REG_LIVE:  bus_rdata_o = live;
            REG_LATCH: bus_rdata_o = lat;
            REG_MASK:  bus_rdata_o = mask;
            default:   bus_rdata_o[CFG_W-1:0] = cfg_q;
        endcase
    end

    // R4: the clear command bit never reads back as set
    a_r4_self_clear: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.clr);
    // R8: disabled mode keeps an active-low open-drain pin released
    a_r8_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == PIN_OFF && !cfg_q.pol && !cfg_q.push_pull) |-> !irq_oe_o);
    // R11: writes to read-only views leave the latches alone
    a_r11_ro: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && addr == REG_LATCH && evt_i == '0) |=> (lat == $past(lat)));
endmodule

// File: tb/sim_irq_ctl.sv
module sim_irq_ctl;
    localparam int NS = 8;
    localparam int PC = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          active_i = 1'b0;
    logic [NS-1:0] evt_i = '0;
    logic          bus_wr_i = 1'b0;
    logic [1:0]    bus_addr_i = '0;
    logic [NS-1:0] bus_wdata_i = '0;
    logic [NS-1:0] bus_rdata_o;
    logic          irq_o, irq_oe_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_ctl #(
        .NUM_SRC(NS), .HAS_LIVE(8'h0F), .MASK_INIT(8'h0F), .PULSE_CYCLES(PC)
    ) u0 (
        .clk(clk), .rst(rst), .active_i(active_i), .evt_i(evt_i),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
    );

    // act, evt, wr, addr, wdata, exp_rd, exp_o, exp_oe
    typedef struct packed {
        logic          act;
        logic [NS-1:0] evt;
        logic          wr;
        logic [1:0]    addr;
        logic [NS-1:0] wdata;
        logic [NS-1:0] exp_rd;
        logic          exp_o;
        logic          exp_oe;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h01, 1'b0, 2'd0, 8'h00, 8'h01, 1'b0, 1'b0}, // R2 live, masked
        '{1'b1, 8'h00, 1'b0, 2'd1, 8'h00, 8'h01, 1'b0, 1'b0}, // R3 sticky
        '{1'b1, 8'h10, 1'b0, 2'd1, 8'h00, 8'h11, 1'b0, 1'b1}, // R5 unmasked latch
        '{1'b0, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 1'b1}, // R2 live off
        '{1'b0, 8'h00, 1'b0, 2'd1, 8'h00, 8'h11, 1'b0, 1'b1}, // R3 survives
        '{1'b0, 8'h00, 1'b1, 2'd2, 8'hFF, 8'hFF, 1'b0, 1'b0}, // R5 mask all
        '{1'b0, 8'h00, 1'b1, 2'd2, 8'h0E, 8'h0E, 1'b0, 1'b1}, // R5 unmask bit0
        '{1'b0, 8'h00, 1'b1, 2'd0, 8'hAA, 8'h00, 1'b0, 1'b1}, // R11 live ro
        '{1'b0, 8'h00, 1'b1, 2'd1, 8'h00, 8'h11, 1'b0, 1'b1}, // R11 latch ro
        '{1'b0, 8'h00, 1'b1, 2'd3, 8'h08, 8'h00, 1'b0, 1'b0}, // R4 clear
        '{1'b0, 8'h00, 1'b0, 2'd1, 8'h00, 8'h00, 1'b0, 1'b0}, // R4 cleared
        '{1'b0, 8'h00, 1'b1, 2'd3, 8'h01, 8'h01, 1'b0, 1'b1}, // R9 high idle
        '{1'b0, 8'h20, 1'b0, 2'd1, 8'h00, 8'h20, 1'b0, 1'b0}, // R9 high asserted
        '{1'b0, 8'h00, 1'b1, 2'd3, 8'h11, 8'h11, 1'b1, 1'b1}, // R10 push-pull high
        '{1'b0, 8'h00, 1'b1, 2'd3, 8'h10, 8'h10, 1'b0, 1'b1}, // R10 push-pull low
        '{1'b0, 8'h00, 1'b1, 2'd3, 8'h12, 8'h12, 1'b1, 1'b1}, // R6 live mode idle
        '{1'b1, 8'h01, 1'b0, 2'd0, 8'h00, 8'h01, 1'b0, 1'b1}, // R6 live unmasked
        '{1'b1, 8'h02, 1'b0, 2'd0, 8'h00, 8'h02, 1'b1, 1'b1}, // R6 live masked
        '{1'b1, 8'h20, 1'b0, 2'd0, 8'h00, 8'h00, 1'b1, 1'b1}, // R2 no live bit
        '{1'b1, 8'h00, 1'b1, 2'd3, 8'h16, 8'h16, 1'b1, 1'b1}, // R8 disabled
        '{1'b1, 8'h80, 1'b1, 2'd3, 8'h08, 8'h00, 1'b0, 1'b1}, // R4 event wins
        '{1'b1, 8'h00, 1'b0, 2'd1, 8'h00, 8'h80, 1'b0, 1'b1}  // R4 event kept
    };

    task automatic check(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic [NS-1:0] e, input logic w,
                         input logic [1:0] ad, input logic [NS-1:0] wd);
        @(negedge clk);
        active_i = a; evt_i = e; bus_wr_i = w; bus_addr_i = ad; bus_wdata_i = wd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pulses;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        bus_addr_i = 2'd0; #1; check("R1 live", bus_rdata_o, 8'h00);
        bus_addr_i = 2'd1; #1; check("R1 latch", bus_rdata_o, 8'h00);
        bus_addr_i = 2'd2; #1; check("R1 mask", bus_rdata_o, 8'h0F);
        bus_addr_i = 2'd3; #1; check("R1 cfg", bus_rdata_o, 8'h00);
        check("R1 oe", {7'd0, irq_oe_o}, 8'h00);
        check("R1 o", {7'd0, irq_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].act, VECS[i].evt, VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            check($sformatf("vec%0d rd", i), bus_rdata_o, VECS[i].exp_rd);
            check($sformatf("vec%0d o", i), {7'd0, irq_o}, {7'd0, VECS[i].exp_o});
            check($sformatf("vec%0d oe", i), {7'd0, irq_oe_o}, {7'd0, VECS[i].exp_oe});
        end

        // R7 pulse mode: clear latches, pulse mode, open-drain, active low
        drive(1'b1, 8'h00, 1'b1, 2'd3, 8'h0C);
        check("R7 idle", {7'd0, irq_oe_o}, 8'h00);
        drive(1'b1, 8'h10, 1'b0, 2'd1, 8'h00);
        pulses = irq_oe_o ? 1 : 0;
        check("R7 starts", {7'd0, irq_oe_o}, 8'h01);
        for (int k = 0; k < 7; k++) begin
            drive(1'b1, 8'h00, 1'b0, 2'd1, 8'h00);
            if (irq_oe_o) pulses++;
        end
        check("R7 length", 8'(pulses), 8'(PC));
        // already latched source: no new pulse
        pulses = 0;
        drive(1'b1, 8'h10, 1'b0, 2'd1, 8'h00);
        for (int k = 0; k < 3; k++) begin
            if (irq_oe_o) pulses++;
            drive(1'b1, 8'h00, 1'b0, 2'd1, 8'h00);
        end
        check("R7 no retrigger", 8'(pulses), 8'd0);
        // masked source (bit 2, mask 0E): no pulse
        drive(1'b1, 8'h04, 1'b0, 2'd1, 8'h00);
        check("R7 masked latch", bus_rdata_o, 8'h14);
        check("R7 masked no pulse", {7'd0, irq_oe_o}, 8'h00);

        // R8 disabled mode with fresh unmasked event
        drive(1'b1, 8'h00, 1'b1, 2'd3, 8'h06);
        drive(1'b1, 8'h40, 1'b0, 2'd1, 8'h00);
        check("R8 off", {7'd0, irq_oe_o}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule